// File: doc/BRIEF.md
# Range-Limited LFSR Permutation Sequencer

This block hands out the integers 0 to N-1 in a scrambled order, each one exactly once. It does this with a maximal-length shift register. At configuration it picks a register width just large enough for the requested count N, loads a seed and works out a correction period for the chosen spin. On each request it steps the register until it reaches a value no greater than N-1, then presents that value for one cycle. Once N values have been issued, further requests get an "exhausted" pulse instead of a value.

The spin setting adds extra register steps to every output, so that consecutive outputs are further apart in the register's sequence. When the step count per output shares a factor with the register period, the outputs would only walk a subset of the states. To prevent this, a countdown inserts one extra step on a computed period, so the walk moves on to the next subset and every state is still visited.

Top module: `lfsr_perm_seq`

## Requirements
- R1: The register width is the smallest w, from 3 up to VAL_W, for which 2^w is strictly greater than N. For example, N=8 gives width 4 and N=2^63-1 gives width 63.
- R2: One register step computes next = ((v >> 1) OR 2^(w-1)) XOR (v[0] ? 0 : F). F is the feedback mask, which has bit t-1 set for each tap t of width w. The taps come from a fixed table: width 3 {3,2}, width 4 {4,3}, width 8 {8,6,5,4}, width 16 {16,15,13,4}, width 32 {32,31,29,1}, width 63 {63,62}. The all-ones state of width w locks the register up and is never entered.
- R3: A register value greater than N-1 is discarded and stepping continues. Every emitted value is at most N-1, and N accepted requests emit each of 0..N-1 exactly once.
- R4: The issued count is checked before any stepping. A request accepted after N values have been issued pulses out_none for one cycle and emits no value. done is high while the block is ready and N values have been issued.
- R5: An ordinary attempt performs spin+1 register steps, one per clock cycle. A discarded attempt is followed at once by the next attempt, with no idle cycle. For an attempt ending at edge k, out_valid is high in the cycle after edge k.
- R6: At configuration the block computes a cycle length C. Let M = 2^w-1, d = spin+1, x = M/d and y = M%d. C = x*i + (y*i)/d for the first i in 1..spin with (y*i)%d == 0. If no such i exists, C = 0. When C is nonzero, a countdown starts at C+1 and decrements on every attempt. The attempt that brings it to zero performs spin+2 steps and reloads the countdown with C.
- R7: cfg_start with N = 0, N >= 2^VAL_W, or a seed whose low w bits are all ones raises cfg_err and leaves the block not ready. A good cfg_start clears cfg_err.
- R8: A good cfg_start loads the low w bits of the seed and clears the issued count. Requests are accepted only while ready is high and are ignored otherwise, including before configuration and during the cycle-length computation.
- R9: out_valid and out_none never occur together. out_valid lasts exactly one cycle, and ready is high while it is shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Load a new configuration |
| cfg_count | input | VAL_W+1 | Number of values N |
| cfg_seed | input | VAL_W | Starting register state |
| cfg_spin | input | SPIN_W | Extra steps per output |
| cfg_err | output | 1 | Last configuration was rejected |
| req | input | 1 | Request the next value |
| ready | output | 1 | Idle and able to accept a request |
| out_valid | output | 1 | out_value holds a new value (one cycle) |
| out_value | output | VAL_W | Emitted value |
| out_none | output | 1 | Request found the sequence exhausted (one cycle) |
| done | output | 1 | All N values issued |

## Verification
The delicate overlap is an out-of-range discard that lands on the same attempt boundary as the countdown reaching zero. The next attempt must then take the long step count while the discard restarts stepping without a gap. This is provoked with N=9 at width 4 and spin 2: the register period of 15 is divisible by 3, so corrections fire every five attempts while values 9..14 are thrown away. Each emitted value and its latency in cycles are compared with an arithmetic model built from the step rule and the cycle-length formula. Small configurations are also swept exhaustively to confirm that each one forms a full permutation.

// File: rtl/lfsr_perm_pkg.sv
package lfsr_perm_pkg;

  typedef enum logic [1:0] {S_OFF, S_CALC, S_IDLE, S_STEP} seq_state_e;

  function automatic logic [63:0] tap_bit(input int unsigned t);
    return (t == 0) ? 64'd0 : (64'd1 << (t - 1));
  endfunction

  // Feedback mask: one bit per tap, at position tap-1.
  function automatic logic [63:0] feedback_mask(input logic [5:0] w);
    logic [63:0] m;
    case (w)
      6'd3:  m = tap_bit(3)  | tap_bit(2);
      6'd4:  m = tap_bit(4)  | tap_bit(3);
      6'd5:  m = tap_bit(5)  | tap_bit(3);
      6'd6:  m = tap_bit(6)  | tap_bit(5);
      6'd7:  m = tap_bit(7)  | tap_bit(6);
      6'd8:  m = tap_bit(8)  | tap_bit(6)  | tap_bit(5)  | tap_bit(4);
      6'd9:  m = tap_bit(9)  | tap_bit(5);
      6'd10: m = tap_bit(10) | tap_bit(7);
      6'd11: m = tap_bit(11) | tap_bit(9);
      6'd12: m = tap_bit(12) | tap_bit(6)  | tap_bit(4)  | tap_bit(1);
      6'd13: m = tap_bit(13) | tap_bit(4)  | tap_bit(3)  | tap_bit(1);
      6'd14: m = tap_bit(14) | tap_bit(5)  | tap_bit(3)  | tap_bit(1);
      6'd15: m = tap_bit(15) | tap_bit(14);
      6'd16: m = tap_bit(16) | tap_bit(15) | tap_bit(13) | tap_bit(4);
      6'd17: m = tap_bit(17) | tap_bit(14);
      6'd18: m = tap_bit(18) | tap_bit(11);
      6'd19: m = tap_bit(19) | tap_bit(6)  | tap_bit(2)  | tap_bit(1);
      6'd20: m = tap_bit(20) | tap_bit(17);
      6'd21: m = tap_bit(21) | tap_bit(19);
      6'd22: m = tap_bit(22) | tap_bit(21);
      6'd23: m = tap_bit(23) | tap_bit(18);
      6'd24: m = tap_bit(24) | tap_bit(23) | tap_bit(22) | tap_bit(17);
      6'd25: m = tap_bit(25) | tap_bit(22);
      6'd26: m = tap_bit(26) | tap_bit(6)  | tap_bit(2)  | tap_bit(1);
      6'd27: m = tap_bit(27) | tap_bit(5)  | tap_bit(2)  | tap_bit(1);
      6'd28: m = tap_bit(28) | tap_bit(25);
      6'd29: m = tap_bit(29) | tap_bit(27);
      6'd30: m = tap_bit(30) | tap_bit(6)  | tap_bit(4)  | tap_bit(1);
      6'd31: m = tap_bit(31) | tap_bit(28);
      6'd32: m = tap_bit(32) | tap_bit(31) | tap_bit(29) | tap_bit(1);
      6'd33: m = tap_bit(33) | tap_bit(20);
      6'd34: m = tap_bit(34) | tap_bit(27) | tap_bit(2)  | tap_bit(1);
      6'd35: m = tap_bit(35) | tap_bit(33);
      6'd36: m = tap_bit(36) | tap_bit(25);
      6'd37: m = tap_bit(37) | tap_bit(5)  | tap_bit(4)  | tap_bit(3) | tap_bit(2) | tap_bit(1);
      6'd38: m = tap_bit(38) | tap_bit(6)  | tap_bit(5)  | tap_bit(1);
      6'd39: m = tap_bit(39) | tap_bit(35);
      6'd40: m = tap_bit(40) | tap_bit(38) | tap_bit(21) | tap_bit(19);
      6'd41: m = tap_bit(41) | tap_bit(38);
      6'd42: m = tap_bit(42) | tap_bit(41) | tap_bit(20) | tap_bit(19);
      6'd43: m = tap_bit(43) | tap_bit(42) | tap_bit(38) | tap_bit(37);
      6'd44: m = tap_bit(44) | tap_bit(43) | tap_bit(18) | tap_bit(17);
      6'd45: m = tap_bit(45) | tap_bit(44) | tap_bit(42) | tap_bit(41);
      6'd46: m = tap_bit(46) | tap_bit(45) | tap_bit(26) | tap_bit(25);
      6'd47: m = tap_bit(47) | tap_bit(42);
      6'd48: m = tap_bit(48) | tap_bit(47) | tap_bit(21) | tap_bit(20);
      6'd49: m = tap_bit(49) | tap_bit(40);
      6'd50: m = tap_bit(50) | tap_bit(49) | tap_bit(24) | tap_bit(23);
      6'd51: m = tap_bit(51) | tap_bit(50) | tap_bit(36) | tap_bit(35);
      6'd52: m = tap_bit(52) | tap_bit(49);
      6'd53: m = tap_bit(53) | tap_bit(52) | tap_bit(38) | tap_bit(37);
      6'd54: m = tap_bit(54) | tap_bit(53) | tap_bit(18) | tap_bit(17);
      6'd55: m = tap_bit(55) | tap_bit(31);
      6'd56: m = tap_bit(56) | tap_bit(55) | tap_bit(35) | tap_bit(34);
      6'd57: m = tap_bit(57) | tap_bit(50);
      6'd58: m = tap_bit(58) | tap_bit(39);
      6'd59: m = tap_bit(59) | tap_bit(58) | tap_bit(38) | tap_bit(37);
      6'd60: m = tap_bit(60) | tap_bit(59);
      6'd61: m = tap_bit(61) | tap_bit(60) | tap_bit(46) | tap_bit(45);
      6'd62: m = tap_bit(62) | tap_bit(61) | tap_bit(6)  | tap_bit(5);
      6'd63: m = tap_bit(63) | tap_bit(62);
      default: m = 64'd0;
    endcase
    return m;
  endfunction

  // Smallest width w >= 3 with 2^w > n.
  function automatic logic [5:0] width_for(input logic [63:0] n);
    logic [5:0] w;
    w = 6'd63;
    for (int i = 63; i >= 3; i--) begin
      if (n < (64'd1 << i)) w = i[5:0];
    end
    return w;
  endfunction

endpackage

// File: rtl/perm_lfsr_step.sv
module perm_lfsr_step #(
  parameter int W = 63
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] fb_mask,
  input  logic [W-1:0] top_bit,
  output logic [W-1:0] nxt
);

  // Complemented Galois step: all-ones is the lock-up state.
  always_comb begin
    nxt = ((cur >> 1) | top_bit) ^ (cur[0] ? '0 : fb_mask);
  end

endmodule

// File: rtl/perm_cycle_calc.sv
module perm_cycle_calc #(
  parameter int CNT_W  = 64,
  parameter int SPIN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [5:0]        width,
  input  logic [SPIN_W-1:0] spin,
  output logic              busy,
  output logic [CNT_W-1:0]  cyc_len
);

  localparam int DIV_W = SPIN_W + 1;
  localparam int PRD_W = DIV_W + SPIN_W;
  localparam int IDX_W = $clog2(CNT_W);
  localparam int MAX_K = (1 << SPIN_W) - 1;

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  m_q, m_d, sh_q, sh_d, quo_q, quo_d;
  logic [DIV_W-1:0]  rem_q, rem_d;
  logic [SPIN_W-1:0] spin_q, spin_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  logic [DIV_W-1:0]  divisor;
  logic [DIV_W:0]    trial;
  logic              take;
  logic              found;
  logic [SPIN_W-1:0] mult;
  logic [PRD_W-1:0]  prod, prod_m;

  assign divisor = DIV_W'(spin_q) + DIV_W'(1);
  assign trial   = {rem_q, sh_q[CNT_W-1]};
  assign take    = trial >= {1'b0, divisor};

  // Serial restoring division of M by spin+1, most significant bit first.
  always_comb begin
    busy_d = busy_q;
    m_d    = m_q;
    sh_d   = sh_q;
    quo_d  = quo_q;
    rem_d  = rem_q;
    spin_d = spin_q;
    idx_d  = idx_q;
    if (start) begin
      m_d    = (CNT_W'(1) << width) - CNT_W'(1);
      sh_d   = (CNT_W'(1) << width) - CNT_W'(1);
      quo_d  = '0;
      rem_d  = '0;
      spin_d = spin;
      idx_d  = IDX_W'(CNT_W - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      sh_d  = sh_q << 1;
      quo_d = {quo_q[CNT_W-2:0], take};
      rem_d = take ? DIV_W'(trial - {1'b0, divisor}) : DIV_W'(trial);
      idx_d = idx_q - IDX_W'(1);
      if (idx_q == '0) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      m_q    <= '0;
      sh_q   <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      spin_q <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      m_q    <= m_d;
      sh_q   <= sh_d;
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      spin_q <= spin_d;
      idx_q  <= idx_d;
    end
  end

  // First multiplier i whose remainder product divides evenly.
  always_comb begin
    found = 1'b0;
    mult  = '0;
    for (int k = 1; k <= MAX_K; k++) begin
      prod = PRD_W'(rem_q) * PRD_W'(k);
      if (!found && k <= int'(spin_q) && (prod % PRD_W'(divisor)) == '0) begin
        found = 1'b1;
        mult  = SPIN_W'(k);
      end
    end
    prod_m  = PRD_W'(rem_q) * PRD_W'(mult);
    cyc_len = found ? (quo_q * CNT_W'(mult) + CNT_W'(prod_m / PRD_W'(divisor))) : '0;
  end

  assign busy = busy_q;

  // R6
  cyc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> cyc_len <= m_q);

endmodule

// File: rtl/lfsr_perm_seq.sv
module lfsr_perm_seq
  import lfsr_perm_pkg::*;
#(
  parameter int VAL_W  = 63,
  parameter int SPIN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic [VAL_W:0]    cfg_count,
  input  logic [VAL_W-1:0]  cfg_seed,
  input  logic [SPIN_W-1:0] cfg_spin,
  output logic              cfg_err,
  input  logic              req,
  output logic              ready,
  output logic              out_valid,
  output logic [VAL_W-1:0]  out_value,
  output logic              out_none,
  output logic              done
);

  localparam int CNT_W = VAL_W + 1;
  localparam int STP_W = SPIN_W + 1;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  seq_state_e        state_q, state_d;
  logic [VAL_W-1:0]  lfsr_q, lfsr_d, mask_q, mask_d, top_q, top_d, wmask_q, wmask_d;
  logic [VAL_W-1:0]  max_q, max_d, val_q, val_d;
  logic [CNT_W-1:0]  n_q, n_d, issued_q, issued_d, cd_q, cd_d;
  logic [SPIN_W-1:0] spin_q, spin_d;
  logic [STP_W-1:0]  steps_q, steps_d;
  logic              ov_q, ov_d, none_q, none_d, err_q, err_d;

  // Configuration decode.
  logic [5:0]       w_new;
  logic [VAL_W-1:0] wmask_new, top_new, mask_new;
  logic             cfg_bad, start_ok;

  assign w_new     = width_for(64'(cfg_count));
  assign wmask_new = VAL_W'((CNT_W'(1) << w_new) - CNT_W'(1));
  assign top_new   = VAL_W'(CNT_W'(1) << (w_new - 6'd1));
  assign mask_new  = VAL_W'(feedback_mask(w_new));
  assign cfg_bad   = (cfg_count == '0) || cfg_count[VAL_W]
                   || ((cfg_seed & wmask_new) == wmask_new);
  assign start_ok  = cfg_start && !cfg_bad;

  logic             calc_busy;
  logic [CNT_W-1:0] cyc_len;

  perm_cycle_calc #(.CNT_W(CNT_W), .SPIN_W(SPIN_W)) i_calc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start_ok),
    .width   (w_new),
    .spin    (cfg_spin),
    .busy    (calc_busy),
    .cyc_len (cyc_len)
  );

  logic [VAL_W-1:0] lfsr_step;

  perm_lfsr_step #(.W(VAL_W)) i_step (
    .cur     (lfsr_q),
    .fb_mask (mask_q),
    .top_bit (top_q),
    .nxt     (lfsr_step)
  );

  // Attempt setup: step count and countdown update.
  logic             has_cyc, corr;
  logic [STP_W-1:0] att_steps;
  logic [CNT_W-1:0] cd_adv;

  assign has_cyc   = cyc_len != '0;
  assign corr      = has_cyc && (cd_q == CNT_W'(1));
  assign att_steps = STP_W'(spin_q) + (corr ? STP_W'(2) : STP_W'(1));
  assign cd_adv    = corr ? cyc_len : (has_cyc ? cd_q - CNT_W'(1) : cd_q);

  always_comb begin
    state_d  = state_q;
    lfsr_d   = lfsr_q;
    mask_d   = mask_q;
    top_d    = top_q;
    wmask_d  = wmask_q;
    max_d    = max_q;
    n_d      = n_q;
    issued_d = issued_q;
    cd_d     = cd_q;
    spin_d   = spin_q;
    steps_d  = steps_q;
    val_d    = val_q;
    err_d    = err_q;
    ov_d     = 1'b0;
    none_d   = 1'b0;
    case (state_q)
      S_CALC: begin
        if (!calc_busy) begin
          cd_d    = cyc_len + CNT_W'(1);
          state_d = S_IDLE;
        end
      end
      S_IDLE: begin
        if (req) begin
          if (issued_q == n_q) begin
            none_d = 1'b1;
          end else begin
            issued_d = issued_q + CNT_W'(1);
            steps_d  = att_steps;
            cd_d     = cd_adv;
            state_d  = S_STEP;
          end
        end
      end
      S_STEP: begin
        lfsr_d = lfsr_step;
        if (steps_q == STP_W'(1)) begin
          if (lfsr_step <= max_q) begin
            ov_d    = 1'b1;
            val_d   = lfsr_step;
            state_d = S_IDLE;
          end else begin
            steps_d = att_steps;
            cd_d    = cd_adv;
          end
        end else begin
          steps_d = steps_q - STP_W'(1);
        end
      end
      default: ;
    endcase
    if (cfg_start) begin
      ov_d   = 1'b0;
      none_d = 1'b0;
      if (cfg_bad) begin
        err_d   = 1'b1;
        state_d = S_OFF;
      end else begin
        err_d    = 1'b0;
        state_d  = S_CALC;
        lfsr_d   = cfg_seed & wmask_new;
        mask_d   = mask_new;
        top_d    = top_new;
        wmask_d  = wmask_new;
        n_d      = cfg_count;
        max_d    = VAL_W'(cfg_count - CNT_W'(1));
        spin_d   = cfg_spin;
        issued_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= S_OFF;
      lfsr_q   <= '0;
      mask_q   <= '0;
      top_q    <= '0;
      wmask_q  <= '0;
      max_q    <= '0;
      n_q      <= '0;
      issued_q <= '0;
      cd_q     <= '0;
      spin_q   <= '0;
      steps_q  <= '0;
      val_q    <= '0;
      err_q    <= 1'b0;
      ov_q     <= 1'b0;
      none_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      lfsr_q   <= lfsr_d;
      mask_q   <= mask_d;
      top_q    <= top_d;
      wmask_q  <= wmask_d;
      max_q    <= max_d;
      n_q      <= n_d;
      issued_q <= issued_d;
      cd_q     <= cd_d;
      spin_q   <= spin_d;
      steps_q  <= steps_d;
      val_q    <= val_d;
      err_q    <= err_d;
      ov_q     <= ov_d;
      none_q   <= none_d;
    end
  end

  assign ready     = state_q == S_IDLE;
  assign done      = ready && (issued_q == n_q);
  assign out_valid = ov_q;
  assign out_none  = none_q;
  assign out_value = val_q;
  assign cfg_err   = err_q;

  // R3
  val_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ov_q |-> val_q <= max_q);
  // R4
  issue_bound_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    issued_q <= n_q);
  // R2
  lockup_free_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_IDLE || state_q == S_STEP) |-> lfsr_q != wmask_q);
  // R9
  excl_resp_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(ov_q && none_q));
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ov_q |=> !ov_q);
  // R9
  valid_ready_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ov_q |-> state_q == S_IDLE);

endmodule

// File: tb/test_lfsr_perm_seq.sv
`timescale 1ns/1ps
module test_lfsr_perm_seq;

  localparam int VW = 63;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_start = 1'b0;
  logic [VW:0]   cfg_count = '0;
  logic [VW-1:0] cfg_seed = '0;
  logic [3:0]    cfg_spin = '0;
  logic          req = 1'b0;
  logic          cfg_err, ready, out_valid, out_none, done;
  logic [VW-1:0] out_value;

  int checks = 0;
  int fails  = 0;
  longint cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lfsr_perm_seq i_lfsr_perm_seq (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_count(cfg_count),
    .cfg_seed(cfg_seed), .cfg_spin(cfg_spin), .cfg_err(cfg_err), .req(req),
    .ready(ready), .out_valid(out_valid), .out_value(out_value),
    .out_none(out_none), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !finished) begin
      finished = 1'b1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Requirement-level model of one register step (R2).
  function automatic longint unsigned lstep(input longint unsigned v, input int w,
                                            input longint unsigned fb);
    longint unsigned top = 64'd1 << (w - 1);
    return ((v >> 1) | top) ^ (v[0] ? 64'd0 : fb);
  endfunction

  // Cycle length formula (R6).
  function automatic longint unsigned cyc_of(input int w, input int spin);
    longint unsigned m = (64'd1 << w) - 1;
    longint unsigned d = spin + 1;
    longint unsigned x = m / d;
    longint unsigned y = m % d;
    for (int i = 1; i <= spin; i++)
      if (((y * i) % d) == 0) return x * i + (y * i) / d;
    return 0;
  endfunction

  task automatic configure(input logic [VW:0] n, input logic [VW-1:0] seed,
                           input logic [3:0] spin);
    @(negedge clk);
    cfg_count = n; cfg_seed = seed; cfg_spin = spin; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    for (int t = 0; t < 200 && !ready && !cfg_err; t++) @(negedge clk);
  endtask

  task automatic get(output bit v, output bit none, output longint unsigned val,
                     output int lat);
    int t = 0;
    while (!ready && t < 500) begin @(negedge clk); t++; end
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    while (!out_valid && !out_none && lat < 6000) begin @(negedge clk); lat++; end
    v = out_valid; none = out_none; val = out_value;
  endtask

  task automatic run_perm(input int n, input int seed, input int spin);
    logic [255:0] seen = '0;
    bit v, none; longint unsigned val; int lat; bit ok;
    configure(n, seed, spin);
    check(!cfg_err && ready, "R7 good config accepted", cfg_err, 0);
    for (int i = 0; i < n; i++) begin
      get(v, none, val, lat);
      ok = v && val < n && !seen[val[7:0]];
      check(ok, "R3 permutation value", val, n);
      if (val < 256) seen[val[7:0]] = 1'b1;
    end
    check(done, "R4 done after N", done, 1);
    get(v, none, val, lat);
    check(none && !v && lat == 0, "R4 exhausted pulse", {v, none}, 1);
  endtask

  initial begin
    bit v, none; longint unsigned val, mv, mcd, cyc, first; int lat, steps;
    repeat (3) @(negedge clk);
    // R8: before configuration requests are ignored
    check(!ready && !out_valid && !cfg_err, "R8 reset state", ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check(!out_valid && !out_none && !ready, "R8 request ignored unconfigured",
            out_valid, 0);
    end
    req = 1'b0;

    // R7 rejected configurations
    configure(0, 1, 0);
    check(cfg_err && !ready, "R7 zero count", cfg_err, 1);
    configure(65'd1 << 63, 1, 0);
    check(cfg_err && !ready, "R7 count too large", cfg_err, 1);
    configure(5, 7, 0);
    check(cfg_err && !ready, "R7 lock-up seed", cfg_err, 1);
    configure(5, 15, 0);
    check(cfg_err && !ready, "R7 lock-up seed in low bits", cfg_err, 1);
    configure(5, 8, 0);
    check(!cfg_err && ready, "R7 seed masked to width", cfg_err, 0);

    // R8: not ready during the cycle-length computation
    @(negedge clk);
    cfg_count = 9; cfg_seed = 5; cfg_spin = 2; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    check(!ready, "R8 busy during computation", ready, 0);

    // R1: N=8 must pick width 4 (taps {4,3}); seed 0, spin 0 -> 4 after 1 step
    configure(8, 0, 0);
    get(v, none, val, lat);
    check(v && val == lstep(0, 4, 64'hC) && lat == 1, "R1 width for N=8", val,
          lstep(0, 4, 64'hC));
    // R1: widest register, taps {63,62}
    configure(64'h7FFF_FFFF_FFFF_FFFF, 1, 0);
    get(v, none, val, lat);
    check(v && val == (64'd1 << 62) && lat == 1, "R1 width 63", val, 64'd1 << 62);

    // R2 R5 R6: exact sequence with discards and period correction
    configure(9, 5, 2);
    cyc = cyc_of(4, 2);
    mv = 5; mcd = cyc + 1;
    first = 0;
    for (int i = 0; i < 9; i++) begin
      steps = 0;
      do begin
        int k;
        if (cyc != 0 && mcd == 1) begin k = 4; mcd = cyc; end
        else begin k = 3; if (cyc != 0) mcd = mcd - 1; end
        repeat (k) mv = lstep(mv, 4, 64'hC);
        steps += k;
      end while (mv > 8);
      if (i == 0) first = mv;
      get(v, none, val, lat);
      check(v && val == mv, "R6 exact value with correction", val, mv);
      check(lat == steps, "R5 cycles per output", lat, steps);
    end
    check(done, "R4 done level", done, 1);
    get(v, none, val, lat);
    check(none && !v, "R4 request after exhaustion", v, 0);

    // R8 restart reloads seed and clears count
    configure(9, 5, 2);
    check(!done, "R8 count cleared", done, 0);
    for (int i = 0; i < 4; i++) get(v, none, val, lat);
    configure(9, 5, 2);
    get(v, none, val, lat);
    check(v && val == first, "R8 restart repeats sequence", val, first);

    // R3 R4 sweep of small configurations
    run_perm(1, 0, 0);
    run_perm(2, 3, 1);
    run_perm(7, 1, 6);
    run_perm(8, 2, 0);
    run_perm(8, 0, 6);
    run_perm(9, 5, 2);
    run_perm(15, 7, 4);
    run_perm(15, 1, 14);
    run_perm(16, 9, 2);
    run_perm(31, 4, 3);
    run_perm(33, 10, 2);
    run_perm(40, 17, 6);
    run_perm(63, 1, 8);
    run_perm(64, 5, 0);
    run_perm(100, 3, 4);
    run_perm(130, 77, 14);
    run_perm(255, 1, 2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule